// File: doc/BRIEF.md
# Event Performance Monitoring Unit

This block watches a vector of single-cycle event pulses from an accelerator and counts them. It has four 32-bit event counters and one 64-bit cycle counter. Each event counter picks its source through its own select register. Selection code 0 is a source that never fires. Code 1 fires on every clock. Code k, for k from 2 up to NUM_EVT-1, follows input bit `evt_in[k-2]`. The cycle counter is armed by a programmable start event and halted by a programmable stop event, so a measurement window can be opened and closed by the hardware itself.

Software drives the unit through a simple word-addressed register port with separate write and read addresses. Enable, interrupt-enable, overflow-clear and software-increment operations all take the same bitmask. In that mask, bits 0..3 select event counters 0..3 and bit 31 selects the cycle counter. When a counter wraps, it raises a sticky overflow flag. A single interrupt output reports every overflow flag whose interrupt enable is set.

Register map (word addresses):

| Address | Register |
|---|---|
| 0 | control (bit 0 global run, bit 1 clear event counters, bit 2 clear cycle counter) |
| 1 / 2 | enable set / enable clear |
| 3 | overflow flags |
| 4 / 5 | interrupt-enable set / interrupt-enable clear |
| 6 | software increment |
| 7 | cycle window (start code in bits [9:0], stop code in bits [25:16]) |
| 8 / 9 | cycle counter low / high |
| 16+i | event counter i |
| 24+i | event select i |

Top module: `perf_monitor`

## Requirements
- R1: After reset, all counters, enable bits, overflow flags, interrupt enables and the global run bit are zero, `irq` is 0, and the cycle window reads 0x00000001 (start code 1, stop code 0).
- R2: Every mask operation honours only bits 0..3 (event counters 0..3) and bit 31 (cycle counter). Writing 0xFFFFFFFF to enable-set reads back as 0x8000000F.
- R3: A write to address 1 sets the masked enable bits, and a write to address 2 clears them. Both addresses read back the current enable state, and the enables change only through these two writes.
- R4: An event counter advances only when its select code fires. Code 0 never fires, code 1 fires every cycle, code k (2 <= k < NUM_EVT) fires when `evt_in[k-2]` is high, and any code >= NUM_EVT never fires. Select registers read back their code.
- R5: Events advance a counter only while control bit 0 (global run) and that counter's enable bit are both set. The control register reads back bit 0.
- R6: A write to address 6 adds one to every counter whose mask bit is set, whatever the enable and run state. If a counted event lands in the same cycle, the result is still +1.
- R7: A write to a counter address loads that counter with the written value. It takes priority over any increment in the same cycle, and it does not set an overflow flag.
- R8: Writing control with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter. Neither bit is stored.
- R9: A cycle whose start code fires makes the cycle counter count from the next cycle on, while run and enable bit 31 are set. A cycle whose stop code fires halts it. When both fire in the same cycle, stop wins. The window register is laid out as start in [9:0] and stop in [25:16].
- R10: The cycle counter is 64 bits wide. Address 8 reads and loads bits [31:0], and address 9 reads and loads bits [63:32]. A wrap of the low half carries into the high half in the same cycle.
- R11: A counter that increments from all ones wraps to zero and sets its overflow flag. The flag stays set until a write to address 3 with that bit set, and a new overflow in that same cycle wins over the clear.
- R12: Writes to addresses 4 and 5 set and clear the masked interrupt enables. Both addresses read back the enable state.
- R13: `irq` is a register that equals the OR of (overflow flag AND interrupt enable) from the previous cycle.
- R14: `rd_data` is a register that holds, one cycle later, the contents of the register at `rd_addr`. Unmapped addresses and address 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register write address |
| bus_wdata | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Registered read data |
| evt_in | input | NUM_EVT-2 | Event pulses for select codes 2 and up |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The bound checker watches four things on every cycle. The interrupt must track the enabled overflow flags with exactly one cycle of lag. An overflow flag may drop only after an overflow-clear write. The enable and interrupt-enable state may change only through their own set and clear writes. Neither the event counters nor the cycle counter may move without the global run bit or a register write (for the cycle counter, the run bit together with an armed window).

Some behaviours only the bench scenarios show: the exact counts for each select code, out-of-range codes, the start/stop window length and stop-over-start priority, and the carry from the low half into the high half. The bench also checks the wrap into a flag, the priority of a direct load over an increment, and every readback value. It does this through a per-cycle behavioural model and directed reads with expected constants.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_ENSET  = 5'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_OVF    = 5'd3;
  localparam logic [ADDR_W-1:0] A_IESET  = 5'd4;
  localparam logic [ADDR_W-1:0] A_IECLR  = 5'd5;
  localparam logic [ADDR_W-1:0] A_SWINC  = 5'd6;
  localparam logic [ADDR_W-1:0] A_WIN    = 5'd7;
  localparam logic [ADDR_W-1:0] A_CCLO   = 5'd8;
  localparam logic [ADDR_W-1:0] A_CCHI   = 5'd9;
  localparam logic [ADDR_W-1:0] A_EVCNT  = 5'd16;
  localparam logic [ADDR_W-1:0] A_EVSEL  = 5'd24;
endpackage

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !clr && !ld && (&cnt);
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int unsigned W  = 64,
  parameter int unsigned HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [HW-1:0] ld_val,
  input  logic          run_ok,
  input  logic          sw_inc,
  input  logic          start_hit,
  input  logic          stop_hit,
  output logic [W-1:0]  cnt,
  output logic          running,
  output logic          wrap
);
  logic inc;

  assign inc  = (run_ok && running) || sw_inc;
  assign wrap = inc && !clr && !ld_lo && !ld_hi && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)           running <= 1'b0;
    else if (stop_hit) running <= 1'b0;
    else if (start_hit) running <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (ld_lo) cnt <= {cnt[W-1:HW], ld_val};
    else if (ld_hi) cnt <= {ld_val[W-HW-1:0], cnt[HW-1:0]};
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CYC_W   = 64,
  parameter int unsigned NUM_EVT = 16,
  parameter int unsigned SEL_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [4:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [4:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_EVT-3:0] evt_in,
  output logic               irq
);
  localparam int unsigned EIDX_W = $clog2(NUM_EVT);
  localparam int unsigned CIDX_W = $clog2(NUM_CNT);
  localparam logic [BUS_W-1:0] MASK =
    (BUS_W'(1) << CYC_BIT) | ((BUS_W'(1) << NUM_CNT) - BUS_W'(1));

  function automatic logic ev_hit(input logic [NUM_EVT-1:0] v,
                                  input logic [SEL_W-1:0]   s);
    if (s < SEL_W'(NUM_EVT)) return v[s[EIDX_W-1:0]];
    return 1'b0;
  endfunction

  // Event vector: code 0 never fires, code 1 always fires.
  logic [NUM_EVT-1:0] evt_vec;
  assign evt_vec = {evt_in, 1'b1, 1'b0};

  logic               gen_q;
  logic [BUS_W-1:0]   en_q, ovf_q, ie_q, ovf_set, wmask;
  logic [SEL_W-1:0]   start_q, stop_q;
  logic [SEL_W-1:0]   sel_q [NUM_CNT];
  logic [CNT_W-1:0]   ev_cnt [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] ev_flat;
  logic [NUM_CNT-1:0] ev_wrap;
  logic [CYC_W-1:0]   cc_cnt;
  logic               cc_run, cc_wrap;
  logic               ctrl_wr, swinc_wr;

  assign wmask    = bus_wdata & MASK;
  assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
  assign swinc_wr = bus_we && (bus_addr == A_SWINC);

  // Event counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic inc_i;
    assign inc_i = (gen_q && en_q[i] && ev_hit(evt_vec, sel_q[i])) ||
                   (swinc_wr && bus_wdata[i]);

    pmu_evt_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr    (ctrl_wr && bus_wdata[1]),
      .ld     (bus_we && (bus_addr == A_EVCNT + ADDR_W'(i))),
      .ld_val (bus_wdata[CNT_W-1:0]),
      .inc    (inc_i),
      .cnt    (ev_cnt[i]),
      .wrap   (ev_wrap[i])
    );

    assign ev_flat[i*CNT_W +: CNT_W] = ev_cnt[i];

    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= '0;
      else if (bus_we && (bus_addr == A_EVSEL + ADDR_W'(i)))
        sel_q[i] <= bus_wdata[SEL_W-1:0];
    end
  end

  // Cycle counter
  pmu_cycle_counter #(.W(CYC_W), .HW(BUS_W)) u_cyc (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctrl_wr && bus_wdata[2]),
    .ld_lo     (bus_we && (bus_addr == A_CCLO)),
    .ld_hi     (bus_we && (bus_addr == A_CCHI)),
    .ld_val    (bus_wdata),
    .run_ok    (gen_q && en_q[CYC_BIT]),
    .sw_inc    (swinc_wr && bus_wdata[CYC_BIT]),
    .start_hit (ev_hit(evt_vec, start_q)),
    .stop_hit  (ev_hit(evt_vec, stop_q)),
    .cnt       (cc_cnt),
    .running   (cc_run),
    .wrap      (cc_wrap)
  );

  always_comb begin
    ovf_set = '0;
    ovf_set[NUM_CNT-1:0] = ev_wrap;
    ovf_set[CYC_BIT]     = cc_wrap;
  end

  // Control and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q   <= 1'b0;
      en_q    <= '0;
      ie_q    <= '0;
      ovf_q   <= '0;
      start_q <= SEL_W'(1);
      stop_q  <= '0;
    end else begin
      if (ctrl_wr) gen_q <= bus_wdata[0];
      if (bus_we && bus_addr == A_ENSET) en_q <= en_q | wmask;
      if (bus_we && bus_addr == A_ENCLR) en_q <= en_q & ~wmask;
      if (bus_we && bus_addr == A_IESET) ie_q <= ie_q | wmask;
      if (bus_we && bus_addr == A_IECLR) ie_q <= ie_q & ~wmask;
      if (bus_we && bus_addr == A_WIN) begin
        start_q <= bus_wdata[SEL_W-1:0];
        stop_q  <= bus_wdata[16 +: SEL_W];
      end
      ovf_q <= ((bus_we && bus_addr == A_OVF) ? (ovf_q & ~wmask) : ovf_q) | ovf_set;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ovf_q & ie_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        A_CTRL:            rd_data <= BUS_W'(gen_q);
        A_ENSET, A_ENCLR:  rd_data <= en_q;
        A_OVF:             rd_data <= ovf_q;
        A_IESET, A_IECLR:  rd_data <= ie_q;
        A_WIN:             rd_data <= (BUS_W'(stop_q) << 16) | BUS_W'(start_q);
        A_CCLO:            rd_data <= cc_cnt[BUS_W-1:0];
        A_CCHI:            rd_data <= cc_cnt[CYC_W-1:BUS_W];
        default: begin
          if (rd_addr[4:3] == 2'b10 && rd_addr[2:0] < 3'(NUM_CNT))
            rd_data <= BUS_W'(ev_cnt[rd_addr[CIDX_W-1:0]]);
          else if (rd_addr[4:3] == 2'b11 && rd_addr[2:0] < 3'(NUM_CNT))
            rd_data <= BUS_W'(sel_q[rd_addr[CIDX_W-1:0]]);
        end
      endcase
    end
  end
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CYC_W   = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_we,
  input logic [4:0]               bus_addr,
  input logic                     irq,
  input logic                     gen,
  input logic [31:0]              en,
  input logic [31:0]              ovf,
  input logic [31:0]              ie,
  input logic [NUM_CNT*CNT_W-1:0] ev_flat,
  input logic [CYC_W-1:0]         cc_cnt,
  input logic                     cc_run
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (armed && $past(rst)) |-> (irq == 1'b0 && ev_flat == '0 && en == '0 && ovf == '0));

  // R13
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    irq == $past(|(ovf & ie)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(ovf) & ~ovf) != '0) |-> $past(bus_we && bus_addr == A_OVF));

  // R3
  en_write_only_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (en != $past(en)) |-> $past(bus_we && (bus_addr == A_ENSET || bus_addr == A_ENCLR)));

  // R12
  ie_write_only_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (ie != $past(ie)) |-> $past(bus_we && (bus_addr == A_IESET || bus_addr == A_IECLR)));

  // R5
  evcnt_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(ev_flat) |-> $past(gen || bus_we));

  // R9
  cyc_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(cc_cnt) |-> $past((gen && cc_run) || bus_we));
endmodule

bind perf_monitor pmu_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .irq      (irq),
  .gen      (gen_q),
  .en       (en_q),
  .ovf      (ovf_q),
  .ie       (ie_q),
  .ev_flat  (ev_flat),
  .cc_cnt   (cc_cnt),
  .cc_run   (cc_run)
);

// File: tb/sim_perf_monitor.sv
`timescale 1ns/1ps
module sim_perf_monitor;
  localparam int NE = 16;
  localparam bit [31:0] MK = 32'h8000_000F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NE-3:0] evt_in = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0, cmp_on = 1'b0, scan = 1'b1;
  logic [4:0] pin_addr = '0;

  always #10 clk = ~clk;

  perf_monitor u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned     m_ev [4];
  bit [9:0]        m_sel [4];
  longint unsigned m_cc;
  bit [31:0]       m_en, m_ovf, m_ie, m_rd;
  bit              m_gen, m_run, m_irq;
  bit [9:0]        m_st, m_sp;

  function automatic bit m_hit(input bit [9:0] s);
    if (s == 10'd1) return 1'b1;
    if (s >= 10'd2 && s < 10'(NE)) return evt_in[s - 10'd2];
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(input int a);
    case (a)
      0: return {31'b0, m_gen};
      1, 2: return m_en;
      3: return m_ovf;
      4, 5: return m_ie;
      7: return {6'b0, m_sp, 6'b0, m_st};
      8: return m_cc[31:0];
      9: return m_cc[63:32];
      16, 17, 18, 19: return m_ev[a-16];
      24, 25, 26, 27: return {22'b0, m_sel[a-24]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0: return "R5";
      1, 2: return "R3";
      3: return "R11";
      4, 5: return "R12";
      7: return "R9";
      8, 9: return "R10";
      16, 17, 18, 19, 24, 25, 26, 27: return "R4";
      default: return "R14";
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] setm;
    bit inc, wr;
    int a;
    if (rst) begin
      foreach (m_ev[i]) begin m_ev[i] = 0; m_sel[i] = '0; end
      m_cc = 0; m_en = 0; m_ovf = 0; m_ie = 0; m_gen = 0; m_run = 0;
      m_st = 10'd1; m_sp = 10'd0; m_rd = 0; m_irq = 0;
    end else begin
      wr = bus_we; a = int'(bus_addr);
      m_rd = m_read(int'(rd_addr));
      m_irq = |(m_ovf & m_ie);
      setm = 0;
      for (int i = 0; i < 4; i++) begin
        inc = (m_gen && m_en[i] && m_hit(m_sel[i])) || (wr && a == 6 && bus_wdata[i]);
        if (wr && a == 0 && bus_wdata[1]) m_ev[i] = 0;
        else if (wr && a == 16 + i) m_ev[i] = bus_wdata;
        else if (inc) begin
          if (m_ev[i] == 32'hFFFF_FFFF) setm[i] = 1'b1;
          m_ev[i] = m_ev[i] + 1;
        end
      end
      inc = (m_gen && m_en[31] && m_run) || (wr && a == 6 && bus_wdata[31]);
      if (wr && a == 0 && bus_wdata[2]) m_cc = 0;
      else if (wr && a == 8) m_cc = {m_cc[63:32], bus_wdata};
      else if (wr && a == 9) m_cc = {bus_wdata, m_cc[31:0]};
      else if (inc) begin
        if (m_cc == 64'hFFFF_FFFF_FFFF_FFFF) setm[31] = 1'b1;
        m_cc = m_cc + 1;
      end
      if (m_hit(m_sp)) m_run = 1'b0;
      else if (m_hit(m_st)) m_run = 1'b1;
      if (wr) begin
        case (a)
          0: m_gen = bus_wdata[0];
          1: m_en = m_en | (bus_wdata & MK);
          2: m_en = m_en & ~(bus_wdata & MK);
          3: m_ovf = m_ovf & ~(bus_wdata & MK);
          4: m_ie = m_ie | (bus_wdata & MK);
          5: m_ie = m_ie & ~(bus_wdata & MK);
          7: begin m_st = bus_wdata[9:0]; m_sp = bus_wdata[25:16]; end
          24, 25, 26, 27: m_sel[a-24] = bus_wdata[9:0];
          default: ;
        endcase
      end
      m_ovf = m_ovf | setm;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (rd_data !== m_rd) begin
        fails++;
        $display("FAIL %s model rd_data addr=%0d actual=%h expected=%h",
                 req_of(int'(rd_addr) == 0 ? 0 : int'(rd_addr)), rd_addr, rd_data, m_rd);
      end
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R13 model irq actual=%0b expected=%0b", irq, m_irq);
      end
    end
  end

  // read-address driver: scans every address unless a directed read holds it
  always @(negedge clk) begin
    if (scan) rd_addr <= rd_addr + 5'd1;
    else      rd_addr <= pin_addr;
  end

  // ---------------- tasks ----------------
  task automatic wr(input int a, input bit [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output bit [31:0] v);
    @(posedge clk);
    pin_addr = 5'(a); scan = 1'b0;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
    scan = 1'b1;
  endtask

  task automatic expect_rd(input string req, input int a, input bit [31:0] exp);
    bit [31:0] v;
    rd(a, v);
    checks++;
    if (v !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, v, exp);
    end
  endtask

  task automatic expect_irq(input string req, input bit exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic pulse(input bit [NE-3:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state
    expect_rd("R1", 1, 32'h0);
    expect_rd("R1", 7, 32'h0000_0001);
    expect_rd("R1", 3, 32'h0);
    expect_irq("R1", 1'b0);

    // R2 / R3 mask layout and set/clear
    wr(1, 32'hFFFF_FFFF);
    expect_rd("R2", 1, 32'h8000_000F);
    wr(2, 32'h0000_0005);
    expect_rd("R3", 2, 32'h8000_000A);
    wr(2, 32'hFFFF_FFFF);
    expect_rd("R3", 1, 32'h0);

    // R6 software increment with run off
    wr(6, 32'h8000_0003);
    wr(6, 32'h8000_0003);
    expect_rd("R6", 16, 32'd2);
    expect_rd("R6", 17, 32'd2);
    expect_rd("R6", 18, 32'd0);
    expect_rd("R6", 8, 32'd2);

    // R8 clear operations
    wr(0, 32'h0000_0006);
    expect_rd("R8", 16, 32'd0);
    expect_rd("R8", 8, 32'd0);
    expect_rd("R8", 0, 32'd0);

    // R7 / R11 / R13 load, wrap, overflow, interrupt
    wr(19, 32'hFFFF_FFFE);
    wr(4, 32'h0000_0008);
    expect_rd("R12", 4, 32'h0000_0008);
    wr(6, 32'h0000_0008);
    wr(6, 32'h0000_0008);
    @(negedge clk);
    expect_irq("R13", 1'b1);
    expect_rd("R11", 3, 32'h0000_0008);
    expect_rd("R7", 19, 32'h0);
    wr(3, 32'h0000_0008);
    @(negedge clk);
    expect_irq("R13", 1'b0);
    expect_rd("R11", 3, 32'h0);
    wr(5, 32'hFFFF_FFFF);
    expect_rd("R12", 5, 32'h0);

    // R4 / R5 event selection
    wr(24, 32'd20);            // out of range
    wr(25, 32'd0);             // never
    wr(26, 32'd5);             // evt_in[3]
    wr(1, 32'h0000_0007);
    pulse(14'h0008);           // run off: ignored
    wr(0, 32'h1);
    pulse(14'h0008);
    @(negedge clk);
    pulse(14'h0008);
    pulse(14'h0008);
    pulse(14'h0001);           // unrelated event
    wr(0, 32'h0);
    expect_rd("R4", 18, 32'd3);
    expect_rd("R4", 17, 32'd0);
    expect_rd("R4", 16, 32'd0);
    expect_rd("R4", 26, 32'd5);
    wr(2, 32'hFFFF_FFFF);

    // R9 / R10 cycle window and carry
    wr(7, 32'h0008_0007);      // start code 7, stop code 8
    expect_rd("R9", 7, 32'h0008_0007);
    pulse(14'h0040);           // stop
    wr(9, 32'h0000_0001);
    wr(8, 32'hFFFF_FFFE);
    wr(1, 32'h8000_0000);
    wr(0, 32'h1);
    repeat (3) @(negedge clk);
    expect_rd("R9", 8, 32'hFFFF_FFFE);
    pulse(14'h0020);           // start
    repeat (3) @(negedge clk);
    pulse(14'h0040);           // stop, 5 counted cycles
    pulse(14'h0060);           // start and stop together: stop wins
    repeat (3) @(negedge clk);
    wr(0, 32'h0);
    expect_rd("R9", 8, 32'h0000_0003);
    expect_rd("R10", 9, 32'h0000_0002);
    expect_rd("R14", 12, 32'h0);

    repeat (40) @(negedge clk);   // free scan of all addresses
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule